// File: doc/BRIEF.md
# Table-Driven Waveform PWM Generator

This block plays one periodic waveform out of a sample table and renders it as a one-bit pulse-width-modulated stream. A two-bit selector picks one of four shapes: sine, triangle, sawtooth or square. Each sample is held for a whole number of PWM periods. That whole number is fixed when the design is elaborated, from the system clock rate, the target output frequency and the table and sample widths. One full pass over the table therefore lasts one output period. An external low-pass filter recovers the analog shape. That filter is outside the block.

During elaboration the block checks the frequency it will actually produce against the allowed error. If that error is exceeded, elaboration stops with an error. The default settings are a 100 MHz clock, 8 address bits, 8 sample bits, a 7 Hz target and a 1 Hz tolerance. These give 218 PWM periods per table step and an output of about 6.999 Hz. The selector may change at any time. Its effect appears from the next PWM period on.

Top module: `wavegen_pwm`

## Requirements
- R1: `wave_sel` selects the shape: 2'b00 sine, 2'b01 triangle, 2'b10 sawtooth, 2'b11 square.
- R2: For sample width D and address width A, with TOP = 2^D-1 and DEPTH = 2^A, the sawtooth sample at address a is floor(a*TOP/(DEPTH-1)).
- R3: With H = DEPTH/2 and i = a mod H, the triangle sample is floor(i*TOP/(H-1)) for a < H and floor((H-1-i)*TOP/(H-1)) for a >= H.
- R4: The square sample is TOP for a < DEPTH/2 and 0 otherwise.
- R5: The sine sample is within 1 LSB of round(TOP/2*(1+sin(2*pi*a/DEPTH))).
- R6: A PWM period lasts 2^D clocks. The output is high for exactly `duty` clocks at the start of the period and then stays low until the period ends.
- R7: The table address starts at 0, advances by one every PPS PWM periods and wraps after DEPTH steps. PPS = max(1, round(SYS_CLK_HZ/(OUT_HZ*2^(A+D)))). With the bench settings (A=D=4, 1 MHz clock, 1953 Hz target) PPS is 2.
- R8: The duty value is loaded only at a PWM period boundary. For period j >= 1 it is the sample at address floor(j/PPS) mod DEPTH, taken from the shape selected during the last clock of period j-1. A selector change in the middle of a period leaves that period unchanged.
- R9: Reset is synchronous and active high. While it is asserted the output is low. After release, period 0 is entirely low, and the sequence restarts from address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wave_sel | input | 2 | Waveform shape select |
| pwm_o | output | 1 | Pulse-width-modulated output |

## Verification
The assertions assume that `rst` is high from time zero until the first clock edge. They also assume that `wave_sel` holds a defined two-bit value at every edge. Nothing else is assumed, because any selector value is legal at any time. The stimulus raises reset before the first edge and changes the selector only on falling clock edges. One of those changes falls in the middle of a PWM period, to exercise the boundary-only loading of the duty value.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;

  typedef enum logic [1:0] {
    WAVE_SINE   = 2'b00,
    WAVE_TRI    = 2'b01,
    WAVE_SAW    = 2'b10,
    WAVE_SQUARE = 2'b11
  } wave_kind_e;

  // PWM periods spent on each table address, rounded to nearest, at least 1
  function automatic int periods_per_step(longint sys_hz, longint out_hz, int aw, int dw);
    longint span;
    longint den;
    longint q;
    span = longint'(1) << (aw + dw);
    den  = out_hz * span;
    if (den < 1) den = 1;
    q = (sys_hz + den / 2) / den;
    if (q < 1) q = 1;
    return int'(q);
  endfunction

  // |sys/(pps*2^(aw+dw)) - out| <= tol, kept in integers
  function automatic bit rate_within_tol(longint sys_hz, longint out_hz, longint tol_hz,
                                         int aw, int dw, int pps);
    longint span;
    longint diff;
    span = longint'(pps) << (aw + dw);
    diff = sys_hz - out_hz * span;
    if (diff < 0) diff = -diff;
    return diff <= tol_hz * span;
  endfunction

  function automatic int saw_sample(int addr, int aw, int dw);
    longint top;
    longint last;
    top  = (longint'(1) << dw) - 1;
    last = (longint'(1) << aw) - 1;
    if (last < 1) last = 1;
    return int'((longint'(addr) * top) / last);
  endfunction

  function automatic int tri_sample(int addr, int aw, int dw);
    longint top;
    longint half;
    longint idx;
    longint span;
    top  = (longint'(1) << dw) - 1;
    half = longint'(1) << (aw - 1);
    idx  = longint'(addr) % half;
    span = (half > 1) ? half - 1 : 1;
    if (addr < half) return int'((idx * top) / span);
    return int'(((half - 1 - idx) * top) / span);
  endfunction

  function automatic int square_sample(int addr, int aw, int dw);
    longint half;
    half = longint'(1) << (aw - 1);
    if (addr < half) return int'((longint'(1) << dw) - 1);
    return 0;
  endfunction

  // rational sine approximation over each half period, rounded to nearest
  function automatic int sine_sample(int addr, int aw, int dw);
    longint top;
    longint half;
    longint p;
    longint num;
    longint den;
    top  = (longint'(1) << dw) - 1;
    half = longint'(1) << (aw - 1);
    p    = longint'(addr) % half;
    num  = 16 * p * (half - p);
    den  = 5 * half * half - 4 * p * (half - p);
    if (addr < half) return int'((top * (den + num) + den) / (2 * den));
    return int'((top * (den - num) + den) / (2 * den));
  endfunction

endpackage

// File: rtl/wg_step_timer.sv
module wg_step_timer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PPS    = 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] pwm_cnt,
  output logic              period_end,
  output logic              step_fire,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] addr_nxt
);

  localparam logic [DATA_W-1:0] CNT_LAST = '1;

  assign period_end = (pwm_cnt == CNT_LAST);
  assign addr_nxt   = step_fire ? addr_q + 1'b1 : addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_cnt <= '0;
      addr_q  <= '0;
    end else begin
      pwm_cnt <= pwm_cnt + 1'b1;
      addr_q  <= addr_nxt;
    end
  end

  generate
    if (PPS == 1) begin : g_every_period
      assign step_fire = period_end;
    end else begin : g_period_div
      localparam int PER_W = $clog2(PPS);
      localparam logic [PER_W-1:0] PER_LAST = PER_W'(PPS - 1);
      logic [PER_W-1:0] per_q;

      assign step_fire = period_end && (per_q == PER_LAST);

      always_ff @(posedge clk) begin
        if (rst) begin
          per_q <= '0;
        end else if (period_end) begin
          per_q <= (per_q == PER_LAST) ? '0 : per_q + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/wg_wave_rom.sv
module wg_wave_rom
  import wavegen_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] sample
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] sine_t   [DEPTH];
  logic [DATA_W-1:0] tri_t    [DEPTH];
  logic [DATA_W-1:0] saw_t    [DEPTH];
  logic [DATA_W-1:0] square_t [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
      assign sine_t[i]   = DATA_W'(sine_sample(i, ADDR_W, DATA_W));
      assign tri_t[i]    = DATA_W'(tri_sample(i, ADDR_W, DATA_W));
      assign saw_t[i]    = DATA_W'(saw_sample(i, ADDR_W, DATA_W));
      assign square_t[i] = DATA_W'(square_sample(i, ADDR_W, DATA_W));
    end
  endgenerate

  always_comb begin
    unique case (wave_kind_e'(sel))
      WAVE_SINE: sample = sine_t[addr];
      WAVE_TRI:  sample = tri_t[addr];
      WAVE_SAW:  sample = saw_t[addr];
      default:   sample = square_t[addr];
    endcase
  end

endmodule

// File: rtl/wg_pwm_out.sv
module wg_pwm_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              period_end,
  input  logic [DATA_W-1:0] sample_nxt,
  input  logic [DATA_W-1:0] pwm_cnt,
  output logic [DATA_W-1:0] duty_q,
  output logic              pwm_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q <= '0;
    end else if (period_end) begin
      duty_q <= sample_nxt;
    end
  end

  assign pwm_o = (pwm_cnt < duty_q);

endmodule

// File: rtl/wavegen_pwm.sv
module wavegen_pwm
  import wavegen_pkg::*;
#(
  parameter int SYS_CLK_HZ = 100_000_000,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int OUT_HZ     = 7,
  parameter int TOL_HZ     = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] wave_sel,
  output logic       pwm_o
);

  localparam int PPS = periods_per_step(longint'(SYS_CLK_HZ), longint'(OUT_HZ), ADDR_W, DATA_W);
  localparam bit RATE_OK = rate_within_tol(longint'(SYS_CLK_HZ), longint'(OUT_HZ),
                                           longint'(TOL_HZ), ADDR_W, DATA_W, PPS);

  generate
    if (!RATE_OK) begin : g_bad_rate
      $error("wavegen_pwm: no period divider meets the frequency tolerance");
    end
    if (ADDR_W < 2) begin : g_bad_addr
      $error("wavegen_pwm: ADDR_W must be at least 2");
    end
  endgenerate

  logic [DATA_W-1:0] pwm_cnt;
  logic              period_end;
  logic              step_fire;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_nxt;
  logic [DATA_W-1:0] sample_nxt;
  logic [DATA_W-1:0] duty_q;

  wg_step_timer #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PPS    (PPS)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .pwm_cnt    (pwm_cnt),
    .period_end (period_end),
    .step_fire  (step_fire),
    .addr_q     (addr_q),
    .addr_nxt   (addr_nxt)
  );

  wg_wave_rom #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_rom (
    .sel    (wave_sel),
    .addr   (addr_nxt),
    .sample (sample_nxt)
  );

  wg_pwm_out #(
    .DATA_W (DATA_W)
  ) u_pwm (
    .clk        (clk),
    .rst        (rst),
    .period_end (period_end),
    .sample_nxt (sample_nxt),
    .pwm_cnt    (pwm_cnt),
    .duty_q     (duty_q),
    .pwm_o      (pwm_o)
  );

endmodule

// File: rtl/wg_checker.sv
module wg_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pwm_o,
  input logic [DATA_W-1:0] pwm_cnt,
  input logic [DATA_W-1:0] duty_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic              period_end,
  input logic              step_fire
);

  // R6
  cnt_advance_chk: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> pwm_cnt == $past(pwm_cnt) + 1'b1);

  // R6
  pwm_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_o) |-> pwm_cnt == '0);

  // R8
  duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> $stable(duty_q));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_fire |=> $stable(addr_q));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    step_fire |=> addr_q == $past(addr_q) + 1'b1);

  // R7
  step_align_chk: assert property (@(posedge clk) disable iff (rst)
    step_fire |-> period_end);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pwm_cnt == '0 && addr_q == '0 && !pwm_o));

endmodule

bind wavegen_pwm wg_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pwm_o      (pwm_o),
  .pwm_cnt    (pwm_cnt),
  .duty_q     (duty_q),
  .addr_q     (addr_q),
  .period_end (period_end),
  .step_fire  (step_fire)
);

// File: tb/tb_wavegen_pwm.sv
module tb_wavegen_pwm;

  localparam int CLK_PERIOD = 10;
  localparam int AW      = 4;
  localparam int DW      = 4;
  localparam int DEPTH   = 1 << AW;
  localparam int TOP     = (1 << DW) - 1;
  localparam int PWM_LEN = 1 << DW;
  // 1e6 / (1953 * 256) = 2.0001, rounds to 2
  localparam int PPS     = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel = 2'b00;
  logic       pwm_o;

  int n_tests = 0;
  int n_fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wavegen_pwm #(
    .SYS_CLK_HZ (1_000_000),
    .ADDR_W     (AW),
    .DATA_W     (DW),
    .OUT_HZ     (1953),
    .TOL_HZ     (10)
  ) dut (
    .clk      (clk),
    .rst      (rst),
    .wave_sel (sel),
    .pwm_o    (pwm_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_sample(input logic [1:0] s, input int a);
    int  half;
    int  i;
    real v;
    half = DEPTH / 2;
    i    = a % half;
    case (s)
      2'b00: begin
        v = (TOP / 2.0) * (1.0 + $sin(2.0 * 3.14159265358979 * a / DEPTH));
        return $rtoi(v + 0.5);
      end
      2'b01:   return (a < half) ? (i * TOP) / (half - 1) : ((half - 1 - i) * TOP) / (half - 1);
      2'b10:   return (a * TOP) / (DEPTH - 1);
      default: return (a < half) ? TOP : 0;
    endcase
  endfunction

  function automatic int exp_period(input logic [1:0] s, input int j);
    if (j == 0) return 0;
    return exp_sample(s, (j / PPS) % DEPTH);
  endfunction

  // Starts on the falling edge of the first clock of a PWM period and ends on the
  // falling edge of the first clock of the next one.
  task automatic meas(input int chg_at, input logic [1:0] chg_sel,
                      output int hi, output bit shape_ok);
    bit seen_low;
    hi       = 0;
    shape_ok = 1'b1;
    seen_low = 1'b0;
    for (int k = 0; k < PWM_LEN; k++) begin
      if (k == chg_at) sel = chg_sel;
      if (pwm_o) begin
        hi++;
        if (seen_low) shape_ok = 1'b0;
      end else begin
        seen_low = 1'b1;
      end
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(pwm_o == 1'b0, "R9 output low during reset", int'(pwm_o), 0);
    end
    rst = 1'b0;
  endtask

  task automatic t_wave(input logic [1:0] s, input string tag);
    int hi;
    bit shp;
    int ex;
    bit ok;
    sel = s;
    do_reset();
    for (int j = 0; j < DEPTH * PPS + 3; j++) begin
      meas(-1, s, hi, shp);
      ex = exp_period(s, j);
      if (s == 2'b00) ok = (hi - ex <= 1) && (ex - hi <= 1);
      else            ok = (hi == ex);
      check(ok, tag, hi, ex);
      check(shp, "R6 single pulse at period start", int'(shp), 1);
    end
  endtask

  task automatic t_switch();
    int hi;
    bit shp;
    sel = 2'b10;
    do_reset();
    for (int j = 0; j < 5; j++) meas(-1, 2'b10, hi, shp);
    meas(6, 2'b11, hi, shp);
    check(hi == exp_sample(2'b10, 2), "R8 period unchanged by mid-period select", hi,
          exp_sample(2'b10, 2));
    meas(-1, 2'b11, hi, shp);
    check(hi == exp_sample(2'b11, 3), "R8 new select from next period", hi, exp_sample(2'b11, 3));
    meas(-1, 2'b11, hi, shp);
    check(hi == exp_sample(2'b11, 3), "R8/R4 new select held", hi, exp_sample(2'b11, 3));
  endtask

  task automatic t_reset_mid();
    int hi;
    bit shp;
    sel = 2'b11;
    do_reset();
    meas(-1, 2'b11, hi, shp);
    meas(-1, 2'b11, hi, shp);
    repeat (3) @(negedge clk);
    check(pwm_o == 1'b1, "R6 square output high early in period", int'(pwm_o), 1);
    rst = 1'b1;
    @(negedge clk);
    check(pwm_o == 1'b0, "R9 reset forces output low at once", int'(pwm_o), 0);
    @(negedge clk);
    rst = 1'b0;
    meas(-1, 2'b11, hi, shp);
    check(hi == 0, "R9 first period after reset is low", hi, 0);
    meas(-1, 2'b11, hi, shp);
    check(hi == TOP, "R9 restart from address 0", hi, TOP);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fails);
    $finish;
  end

  initial begin
    do_reset();
    t_wave(2'b00, "R1/R5 sine (select 00)");
    t_wave(2'b01, "R1/R3 triangle (select 01)");
    t_wave(2'b10, "R1/R2/R7 sawtooth (select 10)");
    t_wave(2'b11, "R1/R4 square (select 11)");
    t_switch();
    t_reset_mid();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fails);
    $finish;
  end

endmodule